// File: doc/BRIEF.md
# Sticky Significand Multiplier

This block multiplies two normalized binary floating-point significands and hands back a product already cut to rounding precision. Each significand carries its leading one explicitly. It is moved to the top of a 64-bit working word. The full 128-bit product is then built from four 32×32 partial products, one per clock, using a single narrow multiplier.

Once the product is complete, its lower 64 bits are folded into one sticky bit. The remaining word is then shifted down to a 56-bit value: the 53 significand bits followed by guard, round and sticky. Every bit removed in that shift is ORed into the lowest bit. The block also returns the sum of the two unbiased exponents, raised by one when the significand product reaches two or more, and the XOR of the operand signs.

A caller pulses `start` with the operands present. It reads the result on the cycle that `done` is high. Bias handling, rounding and any following addition belong to the surrounding datapath.

Top module: `sticky_sig_mul`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and `prod_mant`, `prod_exp` and `prod_sign` are all 0 until the first result.
- R2: With each 53-bit significand placed at bits 63..11 of a 64-bit word, W is the upper 64 bits of the exact 128-bit product, ORed at bit 0 with 1 if the lower 64 bits are non-zero. When W bit 63 is 1, `prod_mant` is W[63:8]. Otherwise it is W[62:7].
- R3: Bit 0 of `prod_mant` is additionally set when any bit shifted out in R2 (W[7:0] or W[6:0] respectively) is 1, so that a product with discarded non-zero bits never reports a clear sticky bit.
- R4: Bit 55 of `prod_mant` is 1 on every result.
- R5: `prod_exp` is the signed sum `exp_a + exp_b`, plus 1 exactly when W bit 63 is 1, in 13-bit two's complement.
- R6: `prod_sign` is `sign_a XOR sign_b`.
- R7: `done` is a one-cycle pulse that goes high 5 clock edges after the edge that accepted `start`. The result outputs keep their value until the next `done`.
- R8: A `start` pulse that arrives while a multiplication is in progress is ignored. It produces no extra `done` and does not change the result.
- R9: Operands are captured on the accepting edge. Changes to the operand inputs during the computation do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| sig_a | input | 53 | First significand, bit 52 set |
| sig_b | input | 53 | Second significand, bit 52 set |
| exp_a | input | 12 | First unbiased exponent, signed |
| exp_b | input | 12 | Second unbiased exponent, signed |
| sign_a | input | 1 | First operand sign |
| sign_b | input | 1 | Second operand sign |
| done | output | 1 | One-cycle result strobe |
| prod_mant | output | 56 | Significand product with guard, round, sticky |
| prod_exp | output | 13 | Exponent of the product, signed |
| prod_sign | output | 1 | Sign of the product |

## Verification
The hidden-bit property holds only if both significands have their top bit (bit 52) set when `start` is accepted. The block does no normalization, so a denormal operand would legitimately yield bit 55 clear. Every significand the stimulus produces, random or directed, is built with bit 52 forced to 1. Exponents are drawn across the full signed 12-bit range, so the 13-bit exponent output cannot wrap.

// File: rtl/sticky_sig_mul_pkg.sv
package sticky_sig_mul_pkg;
  localparam int STEP_W = 2;
  typedef enum logic [STEP_W-1:0] {
    STEP_LL = 2'd0,
    STEP_HH = 2'd1,
    STEP_LH = 2'd2,
    STEP_HL = 2'd3
  } step_e;
endpackage

// File: rtl/sms_half_mul.sv
module sms_half_mul #(
  parameter int HALF_W = 32
) (
  input  logic [HALF_W-1:0]   op_x,
  input  logic [HALF_W-1:0]   op_y,
  output logic [2*HALF_W-1:0] prod
);
  always_comb begin
    prod = {{HALF_W{1'b0}}, op_x} * {{HALF_W{1'b0}}, op_y};
  end
endmodule

// File: rtl/sms_accum.sv
module sms_accum #(
  parameter int WORD_W = 64,
  localparam int HALF_W = WORD_W / 2,
  localparam int ACC_W  = 2 * WORD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                add_en,
  input  sticky_sig_mul_pkg::step_e step,
  input  logic [WORD_W-1:0]   partial,
  output logic [ACC_W-1:0]    acc
);
  import sticky_sig_mul_pkg::*;

  logic [ACC_W-1:0] placed;

  always_comb begin
    case (step)
      STEP_LL: placed = {{WORD_W{1'b0}}, partial};
      STEP_HH: placed = {partial, {WORD_W{1'b0}}};
      default: placed = {{HALF_W{1'b0}}, partial, {HALF_W{1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc <= '0;
    else if (add_en)  acc <= acc + placed;
  end
endmodule

// File: rtl/sms_reduce.sv
module sms_reduce #(
  parameter int WORD_W = 64,
  parameter int OUT_W  = 56,
  localparam int ACC_W = 2 * WORD_W,
  localparam int SH_HI = WORD_W - OUT_W,
  localparam int SH_LO = SH_HI - 1
) (
  input  logic [ACC_W-1:0] prod,
  output logic [OUT_W-1:0] mant,
  output logic             carry
);
  logic [WORD_W-1:0] work;
  logic [OUT_W-1:0]  hi_pick;
  logic [OUT_W-1:0]  lo_pick;

  always_comb begin
    work    = prod[ACC_W-1:WORD_W];
    work[0] = work[0] | (|prod[WORD_W-1:0]);
    carry   = work[WORD_W-1];
    hi_pick = work[WORD_W-1:SH_HI];
    hi_pick[0] = hi_pick[0] | (|work[SH_HI-1:0]);
    lo_pick = work[WORD_W-2:SH_LO];
    lo_pick[0] = lo_pick[0] | (|work[SH_LO-1:0]);
    mant    = carry ? hi_pick : lo_pick;
  end
endmodule

// File: rtl/sticky_sig_mul.sv
module sticky_sig_mul #(
  parameter int SIG_W  = 53,
  parameter int WORD_W = 64,
  parameter int EXP_W  = 12,
  localparam int HALF_W = WORD_W / 2,
  localparam int ALIGN  = WORD_W - SIG_W,
  localparam int OUT_W  = SIG_W + 3,
  localparam int EXPO_W = EXP_W + 1,
  localparam int ACC_W  = 2 * WORD_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [SIG_W-1:0]         sig_a,
  input  logic [SIG_W-1:0]         sig_b,
  input  logic signed [EXP_W-1:0]  exp_a,
  input  logic signed [EXP_W-1:0]  exp_b,
  input  logic                     sign_a,
  input  logic                     sign_b,
  output logic                     done,
  output logic [OUT_W-1:0]         prod_mant,
  output logic signed [EXPO_W-1:0] prod_exp,
  output logic                     prod_sign
);
  import sticky_sig_mul_pkg::*;

  logic [WORD_W-1:0]        a_q, b_q;
  logic signed [EXPO_W-1:0] exp_q;
  logic                     sign_q;
  logic                     busy_q, fin_q;
  step_e                    step_q;
  logic                     accept;
  logic [HALF_W-1:0]        mx, my;
  logic [WORD_W-1:0]        partial;
  logic [ACC_W-1:0]         acc;
  logic [OUT_W-1:0]         red_mant;
  logic                     red_carry;

  assign accept = start && !busy_q;

  always_comb begin
    case (step_q)
      STEP_LL: begin mx = a_q[HALF_W-1:0];      my = b_q[HALF_W-1:0];      end
      STEP_HH: begin mx = a_q[WORD_W-1:HALF_W]; my = b_q[WORD_W-1:HALF_W]; end
      STEP_LH: begin mx = a_q[HALF_W-1:0];      my = b_q[WORD_W-1:HALF_W]; end
      default: begin mx = a_q[WORD_W-1:HALF_W]; my = b_q[HALF_W-1:0];      end
    endcase
  end

  sms_half_mul #(.HALF_W(HALF_W)) u_mul (
    .op_x(mx), .op_y(my), .prod(partial)
  );

  sms_accum #(.WORD_W(WORD_W)) u_acc (
    .clk(clk), .rst(rst), .clear(accept),
    .add_en(busy_q && !fin_q), .step(step_q),
    .partial(partial), .acc(acc)
  );

  sms_reduce #(.WORD_W(WORD_W), .OUT_W(OUT_W)) u_red (
    .prod(acc), .mant(red_mant), .carry(red_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q       <= '0;
      b_q       <= '0;
      exp_q     <= '0;
      sign_q    <= 1'b0;
      busy_q    <= 1'b0;
      fin_q     <= 1'b0;
      step_q    <= STEP_LL;
      done      <= 1'b0;
      prod_mant <= '0;
      prod_exp  <= '0;
      prod_sign <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        a_q    <= {sig_a, {ALIGN{1'b0}}};
        b_q    <= {sig_b, {ALIGN{1'b0}}};
        exp_q  <= {exp_a[EXP_W-1], exp_a} + {exp_b[EXP_W-1], exp_b};
        sign_q <= sign_a ^ sign_b;
        busy_q <= 1'b1;
        fin_q  <= 1'b0;
        step_q <= STEP_LL;
      end else if (busy_q && fin_q) begin
        busy_q    <= 1'b0;
        fin_q     <= 1'b0;
        done      <= 1'b1;
        prod_mant <= red_mant;
        prod_exp  <= exp_q + {{(EXPO_W-1){1'b0}}, red_carry};
        prod_sign <= sign_q;
      end else if (busy_q) begin
        if (step_q == STEP_HL) fin_q <= 1'b1;
        step_q <= step_e'(step_q + 1'b1);
      end
    end
  end
endmodule

// File: rtl/sticky_sig_mul_chk.sv
module sticky_sig_mul_chk #(
  parameter int OUT_W = 56
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [OUT_W-1:0] mant
);
  logic [2:0] since_q;

  always_ff @(posedge clk) begin
    if (rst)                    since_q <= '0;
    else if (start && !busy)    since_q <= 3'd1;
    else if (since_q == 3'd5)   since_q <= '0;
    else if (since_q != 3'd0)   since_q <= since_q + 3'd1;
  end

  p_hidden_set_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> mant[OUT_W-1]);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (since_q == 3'd5) |=> done);

  p_no_stray_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(since_q == 3'd5));

  p_hold_result_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(mant));
endmodule

bind sticky_sig_mul sticky_sig_mul_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy_q),
  .done(done), .mant(prod_mant)
);

// File: tb/sticky_sig_mul_bench.sv
module sticky_sig_mul_bench;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start = 1'b0;
  logic [52:0]        sig_a = '0, sig_b = '0;
  logic signed [11:0] exp_a = '0, exp_b = '0;
  logic               sign_a = 1'b0, sign_b = 1'b0;
  logic               done;
  logic [55:0]        prod_mant;
  logic signed [12:0] prod_exp;
  logic               prod_sign;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sticky_sig_mul u_sticky_sig_mul (
    .clk(clk), .rst(rst), .start(start),
    .sig_a(sig_a), .sig_b(sig_b), .exp_a(exp_a), .exp_b(exp_b),
    .sign_a(sign_a), .sign_b(sign_b),
    .done(done), .prod_mant(prod_mant), .prod_exp(prod_exp),
    .prod_sign(prod_sign)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic logic [56:0] ref_mul(input logic [52:0] a, input logic [52:0] b);
    logic [127:0] full;
    logic [63:0]  w;
    logic [55:0]  m;
    full = {64'd0, a, 11'd0} * {64'd0, b, 11'd0};
    w = full[127:64];
    if (full[63:0] != 0) w[0] = 1'b1;
    if (w[63]) begin
      m = w[63:8];
      if (w[7:0] != 0) m[0] = 1'b1;
    end else begin
      m = w[62:7];
      if (w[6:0] != 0) m[0] = 1'b1;
    end
    return {w[63], m};
  endfunction

  function automatic logic [52:0] rand_sig();
    logic [52:0] s;
    s = {$urandom, $urandom};
    s[52] = 1'b1;
    return s;
  endfunction

  task automatic run_op(input logic [52:0] a, input logic [52:0] b,
                        input logic signed [11:0] ea, input logic signed [11:0] eb,
                        input logic sa, input logic sb);
    logic [56:0]        r;
    logic signed [12:0] ee;
    int                 seen;
    logic [55:0]        held;
    r  = ref_mul(a, b);
    ee = 13'(ea) + 13'(eb) + 13'(r[56]);
    @(negedge clk);
    sig_a = a; sig_b = b; exp_a = ea; exp_b = eb; sign_a = sa; sign_b = sb;
    start = 1'b1;
    seen = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1) begin
        start = 1'b0;
        sig_a = rand_sig(); sig_b = rand_sig();
        exp_a = 12'($urandom); exp_b = 12'($urandom);
        sign_a = ~sa; sign_b = sb;
      end
      if (k == 2) start = 1'b1;
      if (k == 3) start = 1'b0;
      if (done && seen == 0) begin
        seen = k;
        check(prod_mant == r[55:0], "R2/R3 mantissa", 64'(prod_mant), 64'(r[55:0]));
        check(prod_mant[55], "R4 hidden bit", 64'(prod_mant[55]), 64'd1);
        check(prod_exp == ee, "R5 exponent", 64'(prod_exp), 64'(ee));
        check(prod_sign == (sa ^ sb), "R6 sign", 64'(prod_sign), 64'(sa ^ sb));
      end
    end
    check(seen == 6, "R7 latency R9 capture", 64'(seen), 64'd6);
    held = prod_mant;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done) seen++;
    end
    check(seen == 0, "R8 ignored start", 64'(seen), 64'd0);
    check(prod_mant == held, "R7 hold", 64'(prod_mant), 64'(held));
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", 64'(done), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && prod_mant == 0 && prod_exp == 0 && prod_sign == 0,
          "R1 reset state", 64'(prod_mant), 64'd0);
    // directed corners
    run_op(53'h10000000000000, 53'h10000000000000, 12'sd0, 12'sd0, 1'b0, 1'b0);
    run_op(53'h1FFFFFFFFFFFFF, 53'h1FFFFFFFFFFFFF, 12'sd2047, 12'sd2047, 1'b1, 1'b0);
    run_op(53'h10000000000001, 53'h10000000000001, -12'sd2048, -12'sd2048, 1'b1, 1'b1);
    run_op(53'h10000000000000, 53'h1ABCDEF0123457, 12'sd5, -12'sd7, 1'b0, 1'b1);
    run_op(53'h16A09E667F3BCD, 53'h16A09E667F3BCD, 12'sd1, 12'sd1, 1'b0, 1'b0);
    for (int i = 0; i < 300; i++)
      run_op(rand_sig(), rand_sig(), 12'($urandom), 12'($urandom),
             1'($urandom), 1'($urandom));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule